// File: doc/BRIEF.md
# USB PHY Power-Up Reset Sequencer

This block is a hardware state machine that brings a USB host controller and its PHY out of reset in a fixed order. It drives every clock and reset control that the controller samples: the interface clock enable, the power-on reset, the active-low PHY and host resets, and the enable and active-low reset of the host-clock divider and of the full/low-speed (48/12 MHz) divider. It also drives the reference clock select and divide, the host divider ratio, the PHY test-equipment reset pulse and a transmit voltage-reference tune value for each port. Every wait is counted in io-clock cycles. The timed waits are rounded up from the `IO_CLK_HZ` parameter.

Clients ask for the clocks with one-cycle `start_req` pulses and give them back with `stop_req` pulses. A use counter tracks the clients. Only the request that takes the count from zero to one runs the sequence, and only the stop that takes it back to zero turns the interface clock off. `busy` is high while the sequence runs and `ready` is high once it has finished.

Top module: `usbphy_bringup_seq`

## Requirements
- R1: After reset every output is 0: all enables, all resets, `ate_rst`, `hdiv_val`, `ref_sel`, `ref_div`, every port tune field, `busy` and `ready`.
- R2: When `start_req` arrives with the use count at zero, the count becomes one. On the next cycle `if_clk_en` and `busy` go high and `ready` goes low. A start that arrives while the count is nonzero raises the count (the count saturates at its maximum) and has no other effect.
- R3: A `stop_req` lowers a nonzero count. When the count reaches zero, `if_clk_en` and `ready` go low on the next cycle. A stop that arrives with the count at zero leaves the count and all outputs unchanged.
- R4: A `start_req` and a `stop_req` in the same cycle are both ignored.
- R5: One cycle after `if_clk_en` rises, the following happens on the same cycle. `por` goes high. `host_rst_n`, `phy_rst_n`, both divider enables, both divider reset-releases, `ate_rst`, `ref_sel` and `ref_div` go low. `hdiv_val` takes the value `IO_CLK_HZ / HOST_REF_HZ`, using integer division.
- R6: One cycle after R5, `hdiv_en` goes high. One cycle later `hdiv_rst_n` goes high. `por` falls `SYNC_WAIT` (64) cycles after that.
- R7: `por` stays low for ceil(`IO_CLK_HZ`/1000) cycles, the 1 ms wait. `ate_rst` is then high for ceil(10 ns) cycles and low for ceil(20 ns) cycles. Each timed wait lasts at least one cycle.
- R8: After the R7 wait, `fsdiv_rst_n` goes high. `fsdiv_en` follows one cycle later. `phy_rst_n` rises `SYNC_WAIT` cycles after that.
- R9: `host_rst_n` rises ceil(1 µs) cycles after `phy_rst_n`. On the next cycle every port's tune field equals `TUNE_VAL` (15). One cycle after that, `busy` falls and `ready` rises.
- R10: A stop that brings the count to zero while the sequence is running abandons the sequence. On the next cycle `if_clk_en` and `busy` are low. Every other control output keeps its value.
- R11: A later start from zero runs the whole sequence again from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | io clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start_req | input | 1 | one-cycle request for the clocks |
| stop_req | input | 1 | one-cycle release of the clocks |
| if_clk_en | output | 1 | controller interface clock enable |
| por | output | 1 | PHY power-on reset, active high |
| host_rst_n | output | 1 | host controller reset, active low |
| phy_rst_n | output | 1 | PHY reset, active low |
| hdiv_en | output | 1 | host clock divider enable |
| hdiv_rst_n | output | 1 | host clock divider reset release |
| hdiv_val | output | HDIV_W | host clock divide ratio |
| fsdiv_en | output | 1 | 48/12 MHz divider enable |
| fsdiv_rst_n | output | 1 | 48/12 MHz divider reset release |
| ref_sel | output | 2 | reference clock select |
| ref_div | output | 2 | reference clock divide |
| ate_rst | output | 1 | PHY test-equipment reset pulse |
| tx_vref_tune | output | NPORTS*TUNE_W | per-port transmit reference tune, port 0 in the low bits |
| busy | output | 1 | sequence in progress |
| ready | output | 1 | sequence complete |

## Verification
Every control output is registered. Each result therefore appears one cycle after the edge that samples the request or that ends the previous step. For example, `if_clk_en` appears the cycle after the accepted start, `por` the cycle after that, and `host_rst_n` exactly ceil(1 µs) cycles after `phy_rst_n`. The bench keeps a queue of expected output words. When it accepts a start, it fills the queue one word per cycle from the wait lengths given in the requirements. It takes one word off the queue at each rising edge and compares the entire output set on the following falling edge, so a step that comes one cycle early or late fails in that cycle. Stops that reach zero, stops at zero and simultaneous requests are applied to the same model, and their effect is checked on the next falling edge.

// File: rtl/usbphy_seq_pkg.sv
package usbphy_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLKON,
        ST_POR,
        ST_HDEN,
        ST_HDREL,
        ST_PHYCLK,
        ST_ATEHI,
        ST_ATELO,
        ST_FSREL,
        ST_FSEN,
        ST_PRST,
        ST_HRST,
        ST_TUNE,
        ST_READY
    } seq_st_e;

    // cycles of a clock at hz needed to cover ns nanoseconds, rounded up, at least 1
    function automatic longint unsigned wait_cycles(longint unsigned hz, longint unsigned ns);
        longint unsigned c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/usbphy_use_cnt.sv
module usbphy_use_cnt #(
    parameter int UC_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic stop_req,
    output logic first_o,
    output logic last_o
);
    localparam logic [UC_W-1:0] UC_MAX = '1;

    typedef struct packed {
        logic [UC_W-1:0] cnt;
    } uc_t;

    uc_t uc_d, uc_q;
    logic inc_ok, dec_ok;

    always_comb begin
        uc_d    = uc_q;
        inc_ok  = start_req && !stop_req && (uc_q.cnt != UC_MAX);
        dec_ok  = stop_req && !start_req && (uc_q.cnt != '0);
        first_o = start_req && !stop_req && (uc_q.cnt == '0);
        last_o  = dec_ok && (uc_q.cnt == UC_W'(1));
        if (inc_ok)      uc_d.cnt = uc_q.cnt + UC_W'(1);
        else if (dec_ok) uc_d.cnt = uc_q.cnt - UC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) uc_q <= '0;
        else        uc_q <= uc_d;
    end

    AST_STOP_AT_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !start_req && uc_q.cnt == '0) |=> (uc_q.cnt == '0)); // R3
    AST_BOTH_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && start_req) |=> $stable(uc_q.cnt)); // R4

endmodule

// File: rtl/usbphy_wait_tmr.sv
module usbphy_wait_tmr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (load)                tm_d.cnt = load_val;
        else if (tm_q.cnt != '0) tm_d.cnt = tm_q.cnt - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign zero = (tm_q.cnt == '0);

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tm_q.cnt != '0) |=> (tm_q.cnt == $past(tm_q.cnt) - W'(1))); // R7

endmodule

// File: rtl/usbphy_tune_bank.sv
module usbphy_tune_bank #(
    parameter int NPORTS   = 2,
    parameter int TUNE_W   = 4,
    parameter int TUNE_VAL = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     apply,
    output logic [NPORTS*TUNE_W-1:0] tune
);
    localparam logic [TUNE_W-1:0] TV = TUNE_W'(TUNE_VAL);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [TUNE_W-1:0] tune_d, tune_q;

        always_comb begin
            tune_d = tune_q;
            if (apply) tune_d = TV;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tune_q <= '0;
            else        tune_q <= tune_d;
        end

        assign tune[p*TUNE_W +: TUNE_W] = tune_q;

        AST_TUNE_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
            apply |=> (tune[p*TUNE_W +: TUNE_W] == TV)); // R9
    end

endmodule

// File: rtl/usbphy_bringup_seq.sv
module usbphy_bringup_seq
    import usbphy_seq_pkg::*;
#(
    parameter longint unsigned IO_CLK_HZ   = 64'd500_000_000,
    parameter longint unsigned HOST_REF_HZ = 64'd130_000_000,
    parameter int              HDIV_W      = 4,
    parameter int              NPORTS      = 2,
    parameter int              TUNE_W      = 4,
    parameter int              TUNE_VAL    = 15,
    parameter int              UC_W        = 4,
    parameter int              SYNC_WAIT   = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_req,
    input  logic                     stop_req,
    output logic                     if_clk_en,
    output logic                     por,
    output logic                     host_rst_n,
    output logic                     phy_rst_n,
    output logic                     hdiv_en,
    output logic                     hdiv_rst_n,
    output logic [HDIV_W-1:0]        hdiv_val,
    output logic                     fsdiv_en,
    output logic                     fsdiv_rst_n,
    output logic [1:0]               ref_sel,
    output logic [1:0]               ref_div,
    output logic                     ate_rst,
    output logic [NPORTS*TUNE_W-1:0] tx_vref_tune,
    output logic                     busy,
    output logic                     ready
);
    localparam int unsigned T_MS  = 32'(wait_cycles(IO_CLK_HZ, 64'd1_000_000));
    localparam int unsigned T_US  = 32'(wait_cycles(IO_CLK_HZ, 64'd1_000));
    localparam int unsigned T_ATE = 32'(wait_cycles(IO_CLK_HZ, 64'd10));
    localparam int unsigned T_GAP = 32'(wait_cycles(IO_CLK_HZ, 64'd20));
    localparam int unsigned T_SYN = 32'(SYNC_WAIT);
    localparam int unsigned M1    = (T_MS > T_US) ? T_MS : T_US;
    localparam int unsigned M2    = (T_ATE > T_GAP) ? T_ATE : T_GAP;
    localparam int unsigned M3    = (M1 > M2) ? M1 : M2;
    localparam int unsigned WMAX  = (M3 > T_SYN) ? M3 : T_SYN;
    localparam int          TMR_W = $clog2(WMAX + 1);
    localparam logic [HDIV_W-1:0] HDIV_VAL = HDIV_W'(IO_CLK_HZ / HOST_REF_HZ);

    typedef struct packed {
        seq_st_e           st;
        logic              clk_en;
        logic              por;
        logic              hrst_n;
        logic              prst_n;
        logic              hden;
        logic              hdrst_n;
        logic [HDIV_W-1:0] hdiv;
        logic              fsen;
        logic              fsrst_n;
        logic [1:0]        refsel;
        logic [1:0]        refdiv;
        logic              ate;
        logic              busy;
        logic              ready;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic first_start, last_stop;
    logic tmr_load, tmr_zero, tune_apply;
    logic [TMR_W-1:0] tmr_val;

    usbphy_use_cnt #(.UC_W(UC_W)) u_use_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .first_o   (first_start),
        .last_o    (last_stop)
    );

    usbphy_wait_tmr #(.W(TMR_W)) u_wait_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    usbphy_tune_bank #(.NPORTS(NPORTS), .TUNE_W(TUNE_W), .TUNE_VAL(TUNE_VAL)) u_tune_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .apply (tune_apply),
        .tune  (tx_vref_tune)
    );

    always_comb begin
        ctl_d      = ctl_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        tune_apply = 1'b0;
        if (last_stop) begin
            ctl_d.st     = ST_IDLE;
            ctl_d.clk_en = 1'b0;
            ctl_d.busy   = 1'b0;
            ctl_d.ready  = 1'b0;
        end else begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (first_start) begin
                        ctl_d.st     = ST_CLKON;
                        ctl_d.clk_en = 1'b1;
                        ctl_d.busy   = 1'b1;
                        ctl_d.ready  = 1'b0;
                    end
                end
                ST_CLKON: begin
                    ctl_d.st      = ST_POR;
                    ctl_d.por     = 1'b1;
                    ctl_d.hrst_n  = 1'b0;
                    ctl_d.prst_n  = 1'b0;
                    ctl_d.hden    = 1'b0;
                    ctl_d.hdrst_n = 1'b0;
                    ctl_d.fsen    = 1'b0;
                    ctl_d.fsrst_n = 1'b0;
                    ctl_d.refsel  = 2'b00;
                    ctl_d.refdiv  = 2'b00;
                    ctl_d.ate     = 1'b0;
                    ctl_d.hdiv    = HDIV_VAL;
                end
                ST_POR: begin
                    ctl_d.st   = ST_HDEN;
                    ctl_d.hden = 1'b1;
                end
                ST_HDEN: begin
                    ctl_d.st      = ST_HDREL;
                    ctl_d.hdrst_n = 1'b1;
                    tmr_load      = 1'b1;
                    tmr_val       = TMR_W'(T_SYN - 1);
                end
                ST_HDREL: begin
                    if (tmr_zero) begin
                        ctl_d.st  = ST_PHYCLK;
                        ctl_d.por = 1'b0;
                        tmr_load  = 1'b1;
                        tmr_val   = TMR_W'(T_MS - 1);
                    end
                end
                ST_PHYCLK: begin
                    if (tmr_zero) begin
                        ctl_d.st  = ST_ATEHI;
                        ctl_d.ate = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = TMR_W'(T_ATE - 1);
                    end
                end
                ST_ATEHI: begin
                    if (tmr_zero) begin
                        ctl_d.st  = ST_ATELO;
                        ctl_d.ate = 1'b0;
                        tmr_load  = 1'b1;
                        tmr_val   = TMR_W'(T_GAP - 1);
                    end
                end
                ST_ATELO: begin
                    if (tmr_zero) begin
                        ctl_d.st      = ST_FSREL;
                        ctl_d.fsrst_n = 1'b1;
                    end
                end
                ST_FSREL: begin
                    ctl_d.st   = ST_FSEN;
                    ctl_d.fsen = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = TMR_W'(T_SYN - 1);
                end
                ST_FSEN: begin
                    if (tmr_zero) begin
                        ctl_d.st     = ST_PRST;
                        ctl_d.prst_n = 1'b1;
                        tmr_load     = 1'b1;
                        tmr_val      = TMR_W'(T_US - 1);
                    end
                end
                ST_PRST: begin
                    if (tmr_zero) begin
                        ctl_d.st     = ST_HRST;
                        ctl_d.hrst_n = 1'b1;
                    end
                end
                ST_HRST: begin
                    ctl_d.st   = ST_TUNE;
                    tune_apply = 1'b1;
                end
                ST_TUNE: begin
                    ctl_d.st    = ST_READY;
                    ctl_d.busy  = 1'b0;
                    ctl_d.ready = 1'b1;
                end
                ST_READY: begin
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign if_clk_en   = ctl_q.clk_en;
    assign por         = ctl_q.por;
    assign host_rst_n  = ctl_q.hrst_n;
    assign phy_rst_n   = ctl_q.prst_n;
    assign hdiv_en     = ctl_q.hden;
    assign hdiv_rst_n  = ctl_q.hdrst_n;
    assign hdiv_val    = ctl_q.hdiv;
    assign fsdiv_en    = ctl_q.fsen;
    assign fsdiv_rst_n = ctl_q.fsrst_n;
    assign ref_sel     = ctl_q.refsel;
    assign ref_div     = ctl_q.refdiv;
    assign ate_rst     = ctl_q.ate;
    assign busy        = ctl_q.busy;
    assign ready       = ctl_q.ready;

    AST_CLK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> if_clk_en); // R2
    AST_HDIV_EN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdiv_rst_n) |-> hdiv_en); // R6
    AST_ATE_AFTER_POR: assert property (@(posedge clk) disable iff (!rst_n)
        ate_rst |-> !por); // R7
    AST_FSDIV_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsdiv_en) |-> fsdiv_rst_n); // R8
    AST_HRST_AFTER_PRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_rst_n) |-> phy_rst_n); // R9
    AST_BUSY_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && ready)); // R9
    AST_ABORT_DROPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        last_stop |=> (!if_clk_en && !busy)); // R10

endmodule

// File: tb/usbphy_bringup_seq_bench.sv
module usbphy_bringup_seq_bench;

    localparam longint unsigned IO_HZ  = 64'd20_000_000;
    localparam longint unsigned REF_HZ = 64'd5_000_000;
    localparam int T_MS  = 20000;   // ceil(20e6 * 1 ms)
    localparam int T_US  = 20;      // ceil(20e6 * 1 us)
    localparam int T_ATE = 1;       // ceil(0.2) cycles for 10 ns
    localparam int T_GAP = 1;       // ceil(0.4) cycles for 20 ns
    localparam int SYNC  = 64;
    localparam int LIMIT = 190000;

    typedef struct packed {
        logic       clk_en;
        logic       por;
        logic       hrst_n;
        logic       prst_n;
        logic       hden;
        logic       hdrst_n;
        logic [3:0] hdiv;
        logic       fsen;
        logic       fsrst_n;
        logic [1:0] refsel;
        logic [1:0] refdiv;
        logic       ate;
        logic [7:0] tune;
        logic       busy;
        logic       ready;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic stop_req = 1'b0;
    logic if_clk_en, por, host_rst_n, phy_rst_n, hdiv_en, hdiv_rst_n;
    logic fsdiv_en, fsdiv_rst_n, ate_rst, busy, ready;
    logic [3:0] hdiv_val;
    logic [1:0] ref_sel, ref_div;
    logic [7:0] tx_vref_tune;

    always #2.5 clk = ~clk;

    usbphy_bringup_seq #(
        .IO_CLK_HZ(IO_HZ), .HOST_REF_HZ(REF_HZ), .HDIV_W(4), .NPORTS(2),
        .TUNE_W(4), .TUNE_VAL(15), .UC_W(4), .SYNC_WAIT(SYNC)
    ) u_usbphy_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .if_clk_en(if_clk_en), .por(por), .host_rst_n(host_rst_n), .phy_rst_n(phy_rst_n),
        .hdiv_en(hdiv_en), .hdiv_rst_n(hdiv_rst_n), .hdiv_val(hdiv_val),
        .fsdiv_en(fsdiv_en), .fsdiv_rst_n(fsdiv_rst_n), .ref_sel(ref_sel), .ref_div(ref_div),
        .ate_rst(ate_rst), .tx_vref_tune(tx_vref_tune), .busy(busy), .ready(ready)
    );

    exp_t got;
    assign got = {if_clk_en, por, host_rst_n, phy_rst_n, hdiv_en, hdiv_rst_n, hdiv_val,
                  fsdiv_en, fsdiv_rst_n, ref_sel, ref_div, ate_rst, tx_vref_tune, busy, ready};

    // behavioural reference model
    exp_t  cur = '0;
    exp_t  eq[$];
    string tq[$];
    string cur_tag = "R1";
    int    ucnt = 0;
    int    runs = 0;
    int    nchk = 0;
    int    nbad = 0;
    int    cyc  = 0;
    bit    done = 1'b0;

    task automatic push(input exp_t v, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            eq.push_back(v);
            tq.push_back(tag);
        end
    endtask

    task automatic build_seq();
        exp_t v;
        v = cur;
        v.por = 1; v.hrst_n = 0; v.prst_n = 0; v.hden = 0; v.hdrst_n = 0;
        v.fsen = 0; v.fsrst_n = 0; v.refsel = 0; v.refdiv = 0; v.ate = 0;
        v.hdiv = 4'd4;                                   // 20 MHz / 5 MHz
        push(v, 1, "R5");
        v.hden = 1;     push(v, 1, "R6");
        v.hdrst_n = 1;  push(v, SYNC, "R6");
        v.por = 0;      push(v, T_MS, "R7");
        v.ate = 1;      push(v, T_ATE, "R7");
        v.ate = 0;      push(v, T_GAP, "R7");
        v.fsrst_n = 1;  push(v, 1, "R8");
        v.fsen = 1;     push(v, SYNC, "R8");
        v.prst_n = 1;   push(v, T_US, "R9");
        v.hrst_n = 1;   push(v, 1, "R9");
        v.tune = 8'hFF; push(v, 1, "R9");
        v.busy = 0; v.ready = 1; push(v, 1, "R9");
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            cur = '0; ucnt = 0; eq.delete(); tq.delete(); cur_tag = "R1";
        end else begin
            bit f, l, was_ready;
            f = start_req && !stop_req && ucnt == 0;
            l = stop_req && !start_req && ucnt == 1;
            was_ready = cur.ready;
            if (start_req && stop_req) cur_tag = "R4";
            else if (stop_req && ucnt == 0) cur_tag = "R3";
            else if (start_req && ucnt > 0) cur_tag = "R2";
            if (start_req && !stop_req && ucnt < 15) ucnt++;
            else if (stop_req && !start_req && ucnt > 0) ucnt--;
            if (f) begin
                cur.clk_en = 1; cur.busy = 1; cur.ready = 0;
                cur_tag = (runs > 0) ? "R11" : "R2";
                runs++;
                build_seq();
            end else if (l) begin
                eq.delete(); tq.delete();
                cur.clk_en = 0; cur.busy = 0; cur.ready = 0;
                cur_tag = was_ready ? "R3" : "R10";
            end else if (eq.size() > 0) begin
                cur = eq.pop_front();
                cur_tag = tq.pop_front();
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            nchk++;
            if (got !== cur) begin
                nbad++;
                $display("FAIL %s cycle=%0d got=%h exp=%h", cur_tag, cyc, got, cur);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT && !done) begin
            done = 1'b1;
            nbad++;
            $display("FAIL watchdog (R9) got cycles=%0d exp<=%0d", cyc, LIMIT);
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit s, input bit p);
        @(negedge clk);
        start_req = s; stop_req = p;
        @(negedge clk);
        start_req = 0; stop_req = 0;
    endtask

    task automatic wait_ready();
        while (!ready && !done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        idle(5);                 // R1 reset values
        pulse(0, 1);             // R3 stop at zero ignored
        idle(3);
        pulse(1, 1);             // R4 simultaneous requests ignored
        idle(3);
        pulse(1, 0);             // R2 first start, R5..R9 sequence
        idle(100);
        pulse(1, 0);             // R2 extra start counted, ignored
        wait_ready();
        idle(5);
        pulse(0, 1);             // R3 count 2->1, nothing changes
        idle(5);
        pulse(0, 1);             // R3 count 1->0, clock off
        idle(5);
        pulse(1, 0);             // R11 rerun
        idle(5000);
        pulse(0, 1);             // R10 abort mid-sequence
        idle(10);
        pulse(1, 0);             // R11 full rerun after abort
        wait_ready();
        idle(5);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule